// File: doc/BRIEF.md
# Posted Write Buffer with Threshold Drain

This block sits between a write requester and the DRAM command stage. A write that finds room is taken into a small address queue and acknowledged in the same cycle, without waiting for the DRAM write. Queued writes are sent to the command stage in bursts. A burst starts when occupancy rises above a threshold. It also starts when system control asks for a drain while no reads are pending. A burst stops once the buffer is empty or once it has issued a bounded number of writes. A fixed write-to-read turnaround then keeps reads stalled for a few more cycles.

Reads probe the queue through a lookup port. An exact address match means the read can be served from the buffer instead of DRAM, and the lookup reports the queue position of the youngest matching entry. An outside selector may name which queued write goes next, for example a row hit. If it names nothing valid, the oldest write goes.

Top module: `post_wbuf`

## Requirements
- R1: When `wr_valid` is high and fewer than DEPTH entries are queued, `wr_ack` is high in that same cycle and the address is appended as the youngest entry. A repeated address becomes a separate entry.
- R2: When `wr_valid` is high and DEPTH entries are queued, `wr_reject` is high, `wr_ack` is low and the write is discarded. A retry flag is remembered. `wr_retry` pulses for one cycle in the cycle after the next write issue frees a slot, and the flag is then cleared.
- R3: From the idle phase, a drain burst begins (`cmd_valid` and `reads_blocked` high) in the cycle after a clock edge at which occupancy was greater than THRESH.
- R4: A burst ends at the clock edge where its issue leaves the buffer empty, or at the edge of its THRESH+1-th issue, whichever comes first.
- R5: A write issues only in a cycle where `cmd_valid` and `bus_free` are both high. Without `bus_free`, the queue keeps its entries and the burst stays open.
- R6: After a burst ends, `reads_blocked` stays high with `cmd_valid` low for exactly TWTR cycles. The block then returns to idle, where a new burst may start.
- R7: `rd_hit` is high in the same cycle as `rd_valid` exactly when `rd_addr` equals the address of some queued entry.
- R8: On a hit, `rd_pos` gives the queue position of the youngest matching entry. Position 0 is the oldest entry.
- R9: From idle, a burst also begins in the cycle after an edge where `drain_req` was high, `rd_pending` was low and the buffer was non-empty. Repeated bursts this way empty the buffer.
- R10: The issued entry is at position `sel_idx` when `sel_en` is high and `sel_idx` is below occupancy, and otherwise at position 0. The remaining entries keep their relative order, and `cmd_addr` shows the entry that would issue.
- R11: After reset the buffer is empty, the phase is idle and `wr_retry` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request present |
| wr_addr | input | AW | Write address |
| wr_ack | output | 1 | Write accepted and acknowledged this cycle |
| wr_reject | output | 1 | Write refused, buffer full |
| wr_retry | output | 1 | One-cycle pulse: resend a refused write |
| rd_valid | input | 1 | Read lookup present |
| rd_addr | input | AW | Read lookup address |
| rd_hit | output | 1 | Read address matches a queued write |
| rd_pos | output | IW | Position of youngest matching entry |
| sel_en | input | 1 | External selector names an entry |
| sel_idx | input | IW | Selected queue position |
| bus_free | input | 1 | Data bus free, command stage can take a write |
| cmd_valid | output | 1 | Write command offered to the DRAM stage |
| cmd_addr | output | AW | Address of the offered write |
| drain_req | input | 1 | System control asks for the buffer to be emptied |
| rd_pending | input | 1 | Reads are waiting elsewhere in the controller |
| reads_blocked | output | 1 | Burst or turnaround in progress, reads stalled |

## Verification
The write answers (`wr_ack`, `wr_reject`) and the lookup answers (`rd_hit`, `rd_pos`) are combinational. They are due in the cycle their request is presented. `cmd_valid`, `cmd_addr` and `reads_blocked` follow registered state and change one edge after the cause: the occupancy crossing, the drain request, or the last issue of a burst. `wr_retry` is due one edge after the freeing issue. The bench drives every input at the falling edge and compares every output shortly after, before the next rising edge. At that rising edge it advances its own queue and phase model with the same inputs, so each expectation lines up with the register count of its result.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DRAIN = 2'd1,
    PH_TURN  = 2'd2
  } phase_t;

  // selected position is usable only when it names a live entry
  function automatic bit sel_usable(input bit en, input int unsigned idx,
                                    input int unsigned occ);
    return en && (idx < occ);
  endfunction

  // a burst closes after its last allowed issue or when the queue runs dry
  function automatic bit burst_done(input int unsigned issued_after,
                                    input int unsigned occ_after,
                                    input int unsigned thresh);
    return (occ_after == 0) || (issued_after > thresh);
  endfunction

endpackage

// File: rtl/wbuf_store.sv
`timescale 1ns/1ps
module wbuf_store #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  input  logic [IW-1:0] pop_idx,
  input  logic [AW-1:0] look_addr,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] occ_next,
  output logic [AW-1:0] pop_addr,
  output logic          look_hit,
  output logic [IW-1:0] look_pos
);

  logic [AW-1:0] slot   [DEPTH];
  logic [AW-1:0] slot_n [DEPTH];
  logic [CW-1:0] base;

  assign base     = occ - CW'(pop);
  assign occ_next = base + CW'(push);
  assign pop_addr = slot[pop_idx];

  // close the gap left by the issued entry, then append the new one
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (pop && (i >= int'(pop_idx)) && (i < DEPTH - 1)) slot_n[i] = slot[i+1];
      else                                                slot_n[i] = slot[i];
    end
    if (push) slot_n[base[IW-1:0]] = push_addr;
  end

  // later positions overwrite earlier ones: youngest match wins
  always_comb begin
    look_hit = 1'b0;
    look_pos = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((i < int'(occ)) && (slot[i] == look_addr)) begin
        look_hit = 1'b1;
        look_pos = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      occ <= occ_next;
      for (int i = 0; i < DEPTH; i++) slot[i] <= slot_n[i];
    end
  end

endmodule

// File: rtl/wbuf_ctrl.sv
`timescale 1ns/1ps
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int THRESH = 4,
  parameter int TWTR   = 3,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int BW    = $clog2(THRESH + 2),
  localparam int TW    = (TWTR > 1) ? $clog2(TWTR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] occ,
  input  logic [CW-1:0] occ_next,
  input  logic          issue,
  input  logic          drain_req,
  input  logic          rd_pending,
  output logic          drain_on,
  output logic          turn_on
);

  phase_t        phase;
  logic [BW-1:0] issued;
  logic [TW-1:0] turn_left;
  logic          start_hi, start_sys, close_now;
  logic [BW-1:0] issued_n;

  assign start_hi  = occ > CW'(THRESH);
  assign start_sys = drain_req && !rd_pending && (occ != '0);
  assign issued_n  = issued + BW'(issue);
  assign close_now = (issue && burst_done(int'(issued_n), int'(occ_next), THRESH))
                     || (occ == '0);

  assign drain_on = (phase == PH_DRAIN);
  assign turn_on  = (phase == PH_TURN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      issued    <= '0;
      turn_left <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          issued <= '0;
          if (start_hi || start_sys) phase <= PH_DRAIN;
        end
        PH_DRAIN: begin
          issued <= issued_n;
          if (close_now) begin
            phase     <= PH_TURN;
            turn_left <= TW'(TWTR - 1);
          end
        end
        PH_TURN: begin
          if (turn_left == '0) phase <= PH_IDLE;
          else                 turn_left <= turn_left - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/post_wbuf.sv
`timescale 1ns/1ps
module post_wbuf
  import wbuf_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DEPTH  = 8,
  parameter int THRESH = 4,
  parameter int TWTR   = 3,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  output logic          wr_ack,
  output logic          wr_reject,
  output logic          wr_retry,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_hit,
  output logic [IW-1:0] rd_pos,
  input  logic          sel_en,
  input  logic [IW-1:0] sel_idx,
  input  logic          bus_free,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  input  logic          drain_req,
  input  logic          rd_pending,
  output logic          reads_blocked
);

  logic [CW-1:0] occ, occ_next;
  logic          full, issue, drain_on, turn_on, look_hit;
  logic [IW-1:0] pick;
  logic          retry_flag;

  assign full      = (occ == CW'(DEPTH));
  assign wr_ack    = wr_valid && !full;
  assign wr_reject = wr_valid && full;
  assign pick      = sel_usable(sel_en, int'(sel_idx), int'(occ)) ? sel_idx : '0;
  assign cmd_valid = drain_on && (occ != '0);
  assign issue     = cmd_valid && bus_free;
  assign rd_hit    = rd_valid && look_hit;
  assign reads_blocked = drain_on || turn_on;

  wbuf_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(wr_ack), .push_addr(wr_addr),
    .pop(issue), .pop_idx(pick),
    .look_addr(rd_addr),
    .occ(occ), .occ_next(occ_next),
    .pop_addr(cmd_addr),
    .look_hit(look_hit), .look_pos(rd_pos)
  );

  wbuf_ctrl #(.DEPTH(DEPTH), .THRESH(THRESH), .TWTR(TWTR)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .occ(occ), .occ_next(occ_next), .issue(issue),
    .drain_req(drain_req), .rd_pending(rd_pending),
    .drain_on(drain_on), .turn_on(turn_on)
  );

  // a refused writer is told to resend once an issue frees a slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retry_flag <= 1'b0;
      wr_retry   <= 1'b0;
    end else begin
      retry_flag <= (retry_flag || wr_reject) && !issue;
      wr_retry   <= (retry_flag || wr_reject) && issue;
    end
  end

endmodule

// File: rtl/wbuf_chk.sv
`timescale 1ns/1ps
module wbuf_chk #(
  parameter int DEPTH  = 8,
  parameter int THRESH = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] occ,
  input logic          issue,
  input logic          drain_on,
  input logic          turn_on,
  input logic          wr_ack,
  input logic          wr_reject,
  input logic          wr_retry,
  input logic          cmd_valid,
  input logic          bus_free,
  input logic          rd_hit
);

  logic [CW:0] burst_seen;

  always_ff @(posedge clk) begin
    if (!rst_n || !drain_on) burst_seen <= '0;
    else if (issue)          burst_seen <= burst_seen + 1'b1;
  end

  // R1
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ack && wr_reject));

  // R1
  ack_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && !issue) |=> (occ == $past(occ) + 1'b1));

  // R2
  reject_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> (occ == CW'(DEPTH)));

  // R2
  retry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_retry |-> $past(issue));

  // R4
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_seen <= (CW+1)'(THRESH + 1));

  // R5
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !bus_free) |=> cmd_valid);

  // R6
  turn_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drain_on) |-> turn_on);

  // R7
  hit_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (occ != '0));

endmodule

bind post_wbuf wbuf_chk #(.DEPTH(DEPTH), .THRESH(THRESH)) u_chk (
  .clk(clk), .rst_n(rst_n), .occ(occ), .issue(issue),
  .drain_on(drain_on), .turn_on(turn_on),
  .wr_ack(wr_ack), .wr_reject(wr_reject), .wr_retry(wr_retry),
  .cmd_valid(cmd_valid), .bus_free(bus_free), .rd_hit(rd_hit)
);

// File: tb/post_wbuf_test.sv
`timescale 1ns/1ps
module post_wbuf_test;

  localparam int AW = 16, D = 8, TH = 4, TWTR = 3;
  localparam int IW = $clog2(D);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, rd_valid = 0, sel_en = 0, bus_free = 0, drain_req = 0, rd_pending = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [IW-1:0] sel_idx = '0;
  logic wr_ack, wr_reject, wr_retry, rd_hit, cmd_valid, reads_blocked;
  logic [IW-1:0] rd_pos;
  logic [AW-1:0] cmd_addr;

  int checks = 0, fails = 0;

  // bench model of the buffer
  int mq[D];
  int mc = 0, mst = 0, mb = 0, mt = 0;
  bit mflag = 0, mretry = 0;

  always #2 clk = ~clk;

  post_wbuf #(.AW(AW), .DEPTH(D), .THRESH(TH), .TWTR(TWTR)) uut (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_pick();
    return (sel_en && int'(sel_idx) < mc) ? int'(sel_idx) : 0;
  endfunction

  function automatic int exp_youngest();
    int p = -1;
    for (int i = mc - 1; i >= 0; i--)
      if (p < 0 && mq[i] == int'(rd_addr)) p = i;
    return p;
  endfunction

  // compare all outputs, then advance the model at the rising edge
  task automatic cyc();
    int pos, idx, nc;
    bit acc, rej, iss;
    #1;
    pos = exp_youngest();
    acc = wr_valid && (mc < D);
    rej = wr_valid && (mc == D);
    check("R1 wr_ack", int'(wr_ack), int'(acc));
    check("R2 wr_reject", int'(wr_reject), int'(rej));
    check("R2 wr_retry", int'(wr_retry), int'(mretry));
    check("R3/R4/R9 cmd_valid", int'(cmd_valid), int'(mst == 1 && mc != 0));
    check("R6 reads_blocked", int'(reads_blocked), int'(mst != 0));
    check("R7 rd_hit", int'(rd_hit), int'(rd_valid && pos >= 0));
    if (rd_valid && pos >= 0) check("R8 rd_pos", int'(rd_pos), pos);
    if (mst == 1 && mc != 0) check("R5 R10 cmd_addr", int'(cmd_addr), mq[exp_pick()]);
    @(posedge clk);
    iss = (mst == 1) && (mc != 0) && bus_free;
    idx = exp_pick();
    nc = mc;
    if (iss) begin
      for (int i = idx; i < D - 1; i++) mq[i] = mq[i+1];
      nc--;
    end
    if (acc) begin mq[nc] = int'(wr_addr); nc++; end
    mretry = (mflag || rej) && iss;
    mflag  = (mflag || rej) && !iss;
    case (mst)
      0: if (mc > TH || (drain_req && !rd_pending && mc != 0)) begin mst = 1; mb = 0; end
      1: begin
        if (iss) mb++;
        if ((iss && (nc == 0 || mb == TH + 1)) || mc == 0) begin mst = 2; mt = TWTR - 1; end
      end
      default: if (mt == 0) mst = 0; else mt--;
    endcase
    mc = nc;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 cmd_valid", int'(cmd_valid), 0);
    check("R11 reads_blocked", int'(reads_blocked), 0);
    check("R11 wr_retry", int'(wr_retry), 0);
    rst_n = 1'b1;
    // directed: fill past threshold with bus held busy, then overfill
    for (int k = 0; k < D + 2; k++) begin
      wr_valid = 1; wr_addr = AW'(16 + k);
      cyc();
    end
    wr_valid = 0; rd_valid = 1; rd_addr = AW'(18);
    cyc();
    rd_valid = 0; bus_free = 1;
    repeat (14) cyc();
    // directed: duplicate addresses, youngest match
    wr_valid = 1; wr_addr = 5; cyc();
    wr_addr = 7; cyc();
    wr_addr = 5; cyc();
    wr_valid = 0; rd_valid = 1; rd_addr = 5; cyc();
    rd_valid = 0;
    // directed: system drain with selector picking position 1
    sel_en = 1; sel_idx = 1; drain_req = 1; rd_pending = 0;
    repeat (20) cyc();
    drain_req = 0; sel_en = 0;
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      wr_valid   = ($urandom % 2) == 0;
      wr_addr    = AW'($urandom % 8);
      rd_valid   = ($urandom % 2) == 0;
      rd_addr    = AW'($urandom % 8);
      bus_free   = ($urandom % 10) < 7;
      sel_en     = ($urandom % 2) == 0;
      sel_idx    = IW'($urandom % D);
      drain_req  = ($urandom % 8) == 0;
      rd_pending = ($urandom % 2) == 0;
      cyc();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule